// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is an SPI master that works through a queue of single-byte transfers without help from a processor. Software loads a transmit byte and a command byte into each of 16 queue slots. It then programs a start slot and an end slot, sets a run bit, and waits for a done flag or an interrupt. For each slot in the range the block shifts the transmit byte out on MOSI, most significant bit first. It shifts the reply in from MISO and stores it in receive storage for that slot. The top bit of the slot's command byte then decides whether chip select stays asserted into the next slot. With that bit, a single start carries a whole multi-byte transaction, for example an opcode, an address and the data phase.

The serial link always uses SPI mode 3 with 8-bit words. SCK idles high, MOSI changes after a falling edge, and MISO is sampled on the rising edge. Each SCK phase lasts a programmable number of system clocks. Chip select drives one of eight active-high lines, and the line is picked by a one-hot selection register. A hold bit, together with a continuation bit in the control register, can keep the select line asserted after the queue finishes. Software can then run the queue again inside the same transaction. The transaction ends when software clears the hold bit.

The sequencer has eight named states. **IDLE** waits for a start; on a start (*go*) it latches the slot range and moves to **LOAD**. **LOAD** fetches the slot's transmit byte, asserts chip select and moves to **LEAD**. **LEAD** is one phase with SCK high, then moves to **SCK_LO**. **SCK_LO** is the low phase; leaving it is the rising edge, which samples MISO. **SCK_HI** is the high phase; it returns to SCK_LO (*next bit*) or, after the eighth bit, goes to **STORE**. **STORE** writes the received byte and picks one of four paths:
- *chain*: go to LOAD, keeping chip select asserted;
- *gap*: go to TRAIL, then LOAD;
- *close*: go to TRAIL, then FINISH;
- *keep*: go straight to FINISH with chip select held.

**TRAIL** is one phase, after which chip select drops. **FINISH** sets the done flag, clears the run bit and returns to IDLE.

Top module: `spiq_master`

Register word addresses:

| Address | Register | Contents |
|---|---|---|
| 0x00 | divider | [7:0] divider; [15:8] reads the fixed format value |
| 0x01 | start slot | slot index |
| 0x02 | end slot | slot index |
| 0x03 | control | bit 7 continue-after, bit 6 run, bit 5 interrupt enable |
| 0x04 | status | bit 0 done |
| 0x05 | hold | bit 0 |
| 0x06 | select | one-hot chip-select line |
| 0x20+2n | transmit | slot n transmit byte |
| 0x40+2n+1 | receive | slot n received byte |
| 0x60+n | command | slot n command byte |

## Requirements
- R1: After reset the registers read as follows: divider word 0x2308, control 0, status 0, hold 0, select 0x01. Also after reset cs_act is 0, sck is 1 and irq is 0.
- R2: Writing control with bit 6 set while idle starts a run. The run processes the slots from the start slot up to the end slot, both included. Each slot sends the byte at transmit word 0x20+2n on MOSI, MSB first.
- R3: The byte received during slot n is stored and read back at receive word 0x40+2n+1.
- R4: The serial link uses mode 3 timing. SCK idles high. Each SCK low phase and each high phase lasts as many system clocks as the divider value in bits [7:0]. A divider write below 8 stores 8. Bits [15:8] of the divider word always read 0x23, which encodes 8 bits per word in [5:2] and mode 3 in [1:0].
- R5: After a slot whose command byte has bit 7 = 0, chip select is released, and it is asserted again for the next slot. After a non-final slot with bit 7 = 1, chip select stays asserted into the next slot.
- R6: After the final slot, chip select stays asserted only when three bits are all 1: that slot's command bit 7, hold bit 0, and control bit 7. Otherwise it is released. When hold is cleared while idle, a held chip select is released.
- R7: When a run completes, status bit 0 sets and control bit 6 clears. Writing status with bit 0 = 0 clears the done flag. irq equals the done flag ANDed with control bit 5.
- R8: A control write with bit 6 set while a run is in progress has no effect on the run.
- R9: When the end slot is lower than the start slot, only the start slot is processed before done.
- R10: cs_act drives only the line held in the select register, and only during a transaction. A select write whose low byte is not exactly one-hot is ignored.
- R11: Writes to odd transmit words and to receive words are ignored. Odd transmit words and even receive words read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq | output | 1 | Queue-done interrupt |
| sck | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_act | output | 8 | One-hot active-high chip-select lines |

## Verification
The bench runs a table of queue programs that cover several corner cases. These include a reversed pointer pair, a full 16-slot run with alternating continue bits, and a held final slot. A design that walked the range exclusively, or that wrapped a reversed range, would log the wrong number of MOSI bytes. Dropping the continue bit, or ignoring the hold and continuation bits at the final slot, would change the count of chip-select releases or leave a line asserted. Directed tests restart the queue in mid-run, write a divider below the minimum, write a two-hot select value, and write odd transmit and receive words. A design that honoured any of these would send extra bytes, run SCK phases that are too short, assert two lines, or alter stored data.

// File: rtl/spiq_pkg.sv
package spiq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_LEAD,
        ST_SCK_LO,
        ST_SCK_HI,
        ST_STORE,
        ST_TRAIL,
        ST_FINISH
    } seq_state_t;

    localparam int ADDR_W = 7;

    localparam logic [ADDR_W-1:0] A_DIV   = 7'h00;
    localparam logic [ADDR_W-1:0] A_FIRST = 7'h01;
    localparam logic [ADDR_W-1:0] A_LAST  = 7'h02;
    localparam logic [ADDR_W-1:0] A_CTRL  = 7'h03;
    localparam logic [ADDR_W-1:0] A_STAT  = 7'h04;
    localparam logic [ADDR_W-1:0] A_HOLD  = 7'h05;
    localparam logic [ADDR_W-1:0] A_CSSEL = 7'h06;

    localparam int TX_BASE  = 'h20;
    localparam int RX_BASE  = 'h40;
    localparam int CMD_BASE = 'h60;

    localparam int CTRL_CONT_BIT = 7;
    localparam int CTRL_RUN_BIT  = 6;
    localparam int CTRL_IE_BIT   = 5;
    localparam int CMD_CONT_BIT  = 7;

    localparam int DIV_MIN = 8;
    // 8 bits per word in [5:2], mode 3 in [1:0]
    localparam logic [7:0] WORD_FMT = 8'h23;

endpackage

// File: rtl/spiq_tick.sv
module spiq_tick #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic [DIVW-1:0] div,
    output logic            expire
);

    logic [DIVW-1:0] cnt;

    assign expire = (cnt == div - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || expire) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/spiq_regs.sv
module spiq_regs
    import spiq_pkg::*;
#(
    parameter int SLOTS = 16,
    parameter int DIVW  = 8,
    parameter int CSW   = 8,
    parameter int DW    = 32,
    localparam int SW   = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic              done_set,
    input  logic              rx_we,
    input  logic [SW-1:0]     cur_slot,
    input  logic [7:0]        rx_byte,
    output logic [7:0]        tx_byte,
    output logic              cmd_cont,
    output logic [DIVW-1:0]   div,
    output logic [SW-1:0]     q_first,
    output logic [SW-1:0]     q_last,
    output logic              ctrl_cont,
    output logic              irq_en,
    output logic              hold,
    output logic [CSW-1:0]    cs_sel,
    output logic              start,
    output logic              run,
    output logic              done
);

    localparam int TX_END  = TX_BASE + 2 * SLOTS;
    localparam int RX_END  = RX_BASE + 2 * SLOTS;
    localparam int CMD_END = CMD_BASE + SLOTS;

    logic [7:0] tx_mem  [SLOTS];
    logic [7:0] rx_mem  [SLOTS];
    logic [7:0] cmd_mem [SLOTS];

    int          a_i;
    logic        in_tx, in_rx, in_cmd;
    logic [SW-1:0] pair_idx, cmd_idx;
    logic [CSW-1:0] sel_new;
    logic        sel_onehot;

    always_comb begin
        a_i      = int'(addr);
        in_tx    = (a_i >= TX_BASE)  && (a_i < TX_END);
        in_rx    = (a_i >= RX_BASE)  && (a_i < RX_END);
        in_cmd   = (a_i >= CMD_BASE) && (a_i < CMD_END);
        pair_idx = addr[SW:1];
        cmd_idx  = addr[SW-1:0];
        sel_new  = wdata[CSW-1:0];
        sel_onehot = (sel_new != '0) && ((sel_new & (sel_new - 1'b1)) == '0);
    end

    assign start    = we && (addr == A_CTRL) && wdata[CTRL_RUN_BIT] && !run;
    assign tx_byte  = tx_mem[cur_slot];
    assign cmd_cont = cmd_mem[cur_slot][CMD_CONT_BIT];

    // control and status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div       <= DIVW'(DIV_MIN);
            q_first   <= '0;
            q_last    <= '0;
            ctrl_cont <= 1'b0;
            irq_en    <= 1'b0;
            hold      <= 1'b0;
            cs_sel    <= CSW'(1);
            run       <= 1'b0;
            done      <= 1'b0;
        end else begin
            if (we) begin
                unique case (addr)
                    A_DIV: begin
                        if (wdata[DIVW-1:0] < DIVW'(DIV_MIN)) div <= DIVW'(DIV_MIN);
                        else                                  div <= wdata[DIVW-1:0];
                    end
                    A_FIRST: q_first <= wdata[SW-1:0];
                    A_LAST:  q_last  <= wdata[SW-1:0];
                    A_CTRL: begin
                        ctrl_cont <= wdata[CTRL_CONT_BIT];
                        irq_en    <= wdata[CTRL_IE_BIT];
                    end
                    A_HOLD:  hold <= wdata[0];
                    A_CSSEL: if (sel_onehot) cs_sel <= sel_new;
                    default: ;
                endcase
            end
            if (done_set)   run <= 1'b0;
            else if (start) run <= 1'b1;
            if (start)         done <= 1'b0;
            else if (done_set) done <= 1'b1;
            else if (we && (addr == A_STAT) && !wdata[0]) done <= 1'b0;
        end
    end

    // slot storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) begin
                tx_mem[i]  <= '0;
                rx_mem[i]  <= '0;
                cmd_mem[i] <= '0;
            end
        end else begin
            if (we && in_tx && !addr[0]) tx_mem[pair_idx] <= wdata[7:0];
            if (we && in_cmd)            cmd_mem[cmd_idx] <= wdata[7:0];
            if (rx_we)                   rx_mem[cur_slot] <= rx_byte;
        end
    end

    // read mux
    always_comb begin
        rdata = '0;
        if (addr == A_DIV) begin
            rdata[DIVW-1:0] = div;
            rdata[15:8]     = WORD_FMT;
        end else if (addr == A_FIRST) begin
            rdata[SW-1:0] = q_first;
        end else if (addr == A_LAST) begin
            rdata[SW-1:0] = q_last;
        end else if (addr == A_CTRL) begin
            rdata[CTRL_CONT_BIT] = ctrl_cont;
            rdata[CTRL_RUN_BIT]  = run;
            rdata[CTRL_IE_BIT]   = irq_en;
        end else if (addr == A_STAT) begin
            rdata[0] = done;
        end else if (addr == A_HOLD) begin
            rdata[0] = hold;
        end else if (addr == A_CSSEL) begin
            rdata[CSW-1:0] = cs_sel;
        end else if (in_tx && !addr[0]) begin
            rdata[7:0] = tx_mem[pair_idx];
        end else if (in_rx && addr[0]) begin
            rdata[7:0] = rx_mem[pair_idx];
        end else if (in_cmd) begin
            rdata[7:0] = cmd_mem[cmd_idx];
        end
    end

endmodule

// File: rtl/spiq_seq.sv
module spiq_seq
    import spiq_pkg::*;
#(
    parameter int SLOTS = 16,
    localparam int SW   = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [SW-1:0] q_first,
    input  logic [SW-1:0] q_last,
    input  logic [7:0]    tx_byte,
    input  logic          cmd_cont,
    input  logic          hold,
    input  logic          ctrl_cont,
    input  logic          miso,
    input  logic          expire,
    output logic          tick_restart,
    output logic [SW-1:0] slot,
    output logic          sck,
    output logic          mosi,
    output logic          cs_on,
    output logic          rx_we,
    output logic [7:0]    rx_byte,
    output logic          done_set,
    output logic          busy
);

    seq_state_t    state, nxt;
    logic [SW-1:0] end_slot;
    logic [7:0]    tx_sh, rx_sh;
    logic [2:0]    bitn;
    logic          more;
    logic          last_slot, keep_final;

    assign last_slot  = (slot == end_slot);
    assign keep_final = cmd_cont && hold && ctrl_cont;

    // next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = ST_LOAD;
            ST_LOAD:   nxt = ST_LEAD;
            ST_LEAD:   if (expire) nxt = ST_SCK_LO;
            ST_SCK_LO: if (expire) nxt = ST_SCK_HI;
            ST_SCK_HI: if (expire) nxt = (bitn == 3'd7) ? ST_STORE : ST_SCK_LO;
            ST_STORE: begin
                if (last_slot) nxt = keep_final ? ST_FINISH : ST_TRAIL;
                else           nxt = cmd_cont ? ST_LOAD : ST_TRAIL;
            end
            ST_TRAIL:  if (expire) nxt = more ? ST_LOAD : ST_FINISH;
            ST_FINISH: nxt = ST_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            slot     <= '0;
            end_slot <= '0;
            tx_sh    <= 8'hFF;
            rx_sh    <= '0;
            bitn     <= '0;
            more     <= 1'b0;
            cs_on    <= 1'b0;
        end else begin
            state <= nxt;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        slot     <= q_first;
                        end_slot <= (q_last < q_first) ? q_first : q_last;
                    end else if (!hold) begin
                        cs_on <= 1'b0;
                    end
                end
                ST_LOAD: begin
                    tx_sh <= tx_byte;
                    bitn  <= '0;
                    cs_on <= 1'b1;
                end
                ST_LEAD: ;
                ST_SCK_LO: if (expire) rx_sh <= {rx_sh[6:0], miso};
                ST_SCK_HI: begin
                    if (expire && bitn != 3'd7) begin
                        tx_sh <= {tx_sh[6:0], 1'b0};
                        bitn  <= bitn + 1'b1;
                    end
                end
                ST_STORE: begin
                    more <= !last_slot;
                    if (!last_slot) slot <= slot + 1'b1;
                end
                ST_TRAIL:  if (expire) cs_on <= 1'b0;
                ST_FINISH: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sck          = 1'b1;
        tick_restart = 1'b0;
        rx_we        = 1'b0;
        done_set     = 1'b0;
        unique case (state)
            ST_IDLE:   tick_restart = 1'b1;
            ST_LOAD:   tick_restart = 1'b1;
            ST_LEAD:   ;
            ST_SCK_LO: sck = 1'b0;
            ST_SCK_HI: ;
            ST_STORE: begin
                tick_restart = 1'b1;
                rx_we        = 1'b1;
            end
            ST_TRAIL:  ;
            ST_FINISH: begin
                tick_restart = 1'b1;
                done_set     = 1'b1;
            end
        endcase
    end

    assign mosi    = tx_sh[7];
    assign rx_byte = rx_sh;
    assign busy    = (state != ST_IDLE);

endmodule

// File: rtl/spiq_master.sv
module spiq_master
    import spiq_pkg::*;
#(
    parameter int SLOTS = 16,
    parameter int DIVW  = 8,
    parameter int CSW   = 8,
    parameter int DW    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              irq,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [CSW-1:0]    cs_act
);

    localparam int SW = $clog2(SLOTS);

    logic            done_set, rx_we, cmd_cont, start, run_bit, stat_done;
    logic            ctrl_cont, irq_en, cfg_hold, cs_on, expire, tick_restart;
    logic            seq_busy;
    logic [SW-1:0]   seq_slot, q_first, q_last;
    logic [7:0]      rx_byte, tx_byte;
    logic [DIVW-1:0] div;
    logic [CSW-1:0]  cs_sel;

    spiq_regs #(.SLOTS(SLOTS), .DIVW(DIVW), .CSW(CSW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .done_set(done_set),
        .rx_we(rx_we), .cur_slot(seq_slot), .rx_byte(rx_byte),
        .tx_byte(tx_byte), .cmd_cont(cmd_cont), .div(div),
        .q_first(q_first), .q_last(q_last), .ctrl_cont(ctrl_cont),
        .irq_en(irq_en), .hold(cfg_hold), .cs_sel(cs_sel),
        .start(start), .run(run_bit), .done(stat_done)
    );

    spiq_tick #(.DIVW(DIVW)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart(tick_restart),
        .div(div), .expire(expire)
    );

    spiq_seq #(.SLOTS(SLOTS)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .q_first(q_first),
        .q_last(q_last), .tx_byte(tx_byte), .cmd_cont(cmd_cont),
        .hold(cfg_hold), .ctrl_cont(ctrl_cont), .miso(miso),
        .expire(expire), .tick_restart(tick_restart), .slot(seq_slot),
        .sck(sck), .mosi(mosi), .cs_on(cs_on), .rx_we(rx_we),
        .rx_byte(rx_byte), .done_set(done_set), .busy(seq_busy)
    );

    assign cs_act = cs_on ? cs_sel : '0;
    assign irq    = stat_done && irq_en;

endmodule

// File: rtl/spiq_chk.sv
module spiq_chk #(
    parameter int SW  = 4,
    parameter int CSW = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           sck,
    input logic [CSW-1:0] cs_act,
    input logic           busy,
    input logic [SW-1:0]  slot,
    input logic           hold,
    input logic           done,
    input logic           run
);

    // R10
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_act));

    // R4
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act == '0) |-> sck);

    // R2
    slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (slot == $past(slot) || slot == $past(slot) + 1'b1));

    // R7
    done_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !run);

    // R6
    hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy) && !$past(hold)) |-> (cs_act == '0));

endmodule

bind spiq_master spiq_chk #(.SW(SW), .CSW(CSW)) u_chk (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_act(cs_act), .busy(seq_busy),
    .slot(seq_slot), .hold(cfg_hold), .done(stat_done), .run(run_bit)
);

// File: tb/spiq_master_tb.sv
module spiq_master_tb;
    import spiq_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        miso = 1'b1;
    wire  [31:0] reg_rdata;
    wire         irq, sck, mosi;
    wire  [7:0]  cs_act;

    always #5 clk = ~clk;

    spiq_master u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .sck(sck), .mosi(mosi), .miso(miso), .cs_act(cs_act)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;

    task automatic check_eq(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rep(int k);
        return 8'hC3 ^ 8'(k * 29);
    endfunction

    function automatic logic [7:0] txv(int s, int vi);
        return 8'(s * 17 + vi * 53 + 5);
    endfunction

    // SPI slave model: mode 3
    int         s_nbyte = 0, s_bit = 0;
    logic [7:0] s_sh = '0, r_t;
    logic [7:0] s_log [64];
    always @(negedge sck) begin
        if (cs_act != 0) begin
            r_t  = rep(s_nbyte);
            miso = r_t[7 - s_bit];
        end
    end
    always @(posedge sck) begin
        if (cs_act != 0) begin
            s_sh = {s_sh[6:0], mosi};
            s_bit++;
            if (s_bit == 8) begin
                if (s_nbyte < 64) s_log[s_nbyte] = s_sh;
                s_nbyte++;
                s_bit = 0;
            end
        end
    end

    // line monitor
    logic [7:0] prev_cs = '0, cs_seen = '0;
    int         n_rel = 0, lowrun = 0, last_low = 0;
    always @(negedge clk) begin
        if (prev_cs != 0 && cs_act == 0) n_rel++;
        prev_cs = cs_act;
        cs_seen = cs_seen | cs_act;
        if (sck == 1'b0) lowrun++;
        else if (lowrun != 0) begin
            last_low = lowrun;
            lowrun   = 0;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic wr(logic [6:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_done();
        logic [31:0] d;
        do rd(A_STAT, d); while (d[0] !== 1'b1);
    endtask

    task automatic clear_mon();
        s_nbyte = 0; s_bit = 0; n_rel = 0; cs_seen = '0;
    endtask

    task automatic program_slots(int vi, logic [15:0] mask);
        for (int s = 0; s < 16; s++) begin
            wr(7'(TX_BASE + 2 * s), 32'(txv(s, vi)));
            wr(7'(CMD_BASE + s), {24'h0, mask[s], 7'h0E});
        end
    endtask

    // {first, last, continue mask, hold, ctrl continue}
    localparam logic [25:0] VECS [7] = '{
        {4'd0,  4'd3,  16'h0007, 1'b0, 1'b0},
        {4'd2,  4'd9,  16'hFFFF, 1'b0, 1'b1},
        {4'd5,  4'd5,  16'h0000, 1'b0, 1'b0},
        {4'd0,  4'd15, 16'h5555, 1'b0, 1'b0},
        {4'd10, 4'd4,  16'h0000, 1'b0, 1'b0},
        {4'd12, 4'd14, 16'hFFFF, 1'b1, 1'b1},
        {4'd3,  4'd4,  16'hFFFF, 1'b1, 1'b0}
    };

    initial begin
        logic [31:0] d, keep;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_DIV, d);   check_eq("R1 divider", d, 32'h2308);
        rd(A_CTRL, d);  check_eq("R1 control", d, 0);
        rd(A_STAT, d);  check_eq("R1 status", d, 0);
        rd(A_HOLD, d);  check_eq("R1 hold", d, 0);
        rd(A_CSSEL, d); check_eq("R1 select", d, 1);
        check_eq("R1 cs_act", 32'(cs_act), 0);
        check_eq("R1 sck", 32'(sck), 1);
        check_eq("R1 irq", 32'(irq), 0);

        // vector table
        for (int vi = 0; vi < 7; vi++) begin
            logic [3:0]  vf, vl;
            logic [15:0] vm;
            logic        vh, vc, ie, held;
            int          n, erel, ls;
            string       rq;
            {vf, vl, vm, vh, vc} = VECS[vi];
            ie = (vi % 2 == 0);
            program_slots(vi, vm);
            wr(A_FIRST, 32'(vf));
            wr(A_LAST, 32'(vl));
            wr(A_HOLD, 32'(vh));
            clear_mon();
            wr(A_CTRL, {24'h0, vc, 1'b1, ie, 5'h0});
            wait_done();
            n  = (vl >= vf) ? int'(vl) - int'(vf) + 1 : 1;
            rq = (vl < vf) ? "R9 byte count" : "R2 byte count";
            check_eq(rq, 32'(s_nbyte), 32'(n));
            erel = 0;
            for (int k = 0; k < n; k++) begin
                int s;
                s = int'(vf) + k;
                check_eq("R2 mosi byte", 32'(s_log[k]), 32'(txv(s, vi)));
                rd(7'(RX_BASE + 2 * s + 1), d);
                check_eq("R3 rx byte", d, 32'(rep(k)));
                if (!vm[s]) erel++;
                else if (k == n - 1 && !(vh && vc)) erel++;
            end
            ls   = int'(vf) + n - 1;
            held = vm[ls] && vh && vc;
            check_eq("R5 releases", 32'(n_rel), 32'(erel));
            check_eq("R6 cs after run", 32'(cs_act != 0), 32'(held));
            rd(A_CTRL, d);
            check_eq("R7 run cleared", 32'(d[6]), 0);
            check_eq("R7 irq", 32'(irq), 32'(ie));
            wr(A_STAT, 0);
            rd(A_STAT, d);
            check_eq("R7 done cleared", d, 0);
            check_eq("R7 irq cleared", 32'(irq), 0);
            if (vh) begin
                wr(A_HOLD, 0);
                @(negedge clk);
                check_eq("R6 hold clear release", 32'(cs_act), 0);
            end
        end

        // R8 restart during run is ignored
        program_slots(6, 16'h0007);
        wr(A_FIRST, 0); wr(A_LAST, 3);
        clear_mon();
        wr(A_CTRL, 32'h40);
        repeat (40) @(negedge clk);
        rd(A_CTRL, d);
        check_eq("R8 running", 32'(d[6]), 1);
        wr(A_CTRL, 32'h40);
        wait_done();
        check_eq("R8 byte count", 32'(s_nbyte), 4);
        wr(A_STAT, 0);

        // R4 divider clamp and phase length
        wr(A_DIV, 3);
        rd(A_DIV, d);  check_eq("R4 clamp", d, 32'h2308);
        wr(A_DIV, 10);
        rd(A_DIV, d);  check_eq("R4 divider 10", d, 32'h230A);
        wr(A_FIRST, 0); wr(A_LAST, 0);
        clear_mon();
        wr(A_CTRL, 32'h40);
        wait_done();
        check_eq("R4 low phase", 32'(last_low), 10);
        wr(A_STAT, 0);
        wr(A_DIV, 8);

        // R10 select register
        wr(A_CSSEL, 32'h03);
        rd(A_CSSEL, d); check_eq("R10 two-hot ignored", d, 1);
        wr(A_CSSEL, 32'h20);
        rd(A_CSSEL, d); check_eq("R10 select", d, 32'h20);
        clear_mon();
        wr(A_CTRL, 32'h40);
        wait_done();
        check_eq("R10 line used", 32'(cs_seen), 32'h20);
        wr(A_STAT, 0);
        wr(A_CSSEL, 1);

        // R11 ignored writes
        rd(7'(RX_BASE + 1), keep);
        wr(7'(RX_BASE + 1), 32'hEE);
        rd(7'(RX_BASE + 1), d); check_eq("R11 rx write", d, keep);
        rd(7'(RX_BASE), d);     check_eq("R11 even rx", d, 0);
        wr(7'(TX_BASE + 1), 32'hAB);
        rd(7'(TX_BASE + 1), d); check_eq("R11 odd tx", d, 0);
        rd(7'(TX_BASE), d);     check_eq("R11 tx intact", d, 32'(txv(0, 6)));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule